// File: doc/BRIEF.md
# Flash Embedded-Operation Status Poller

After a NOR flash device has been handed a program or erase command, this block finds out how the embedded operation ended. It reads one status word, then reads it again, and compares the toggle bit (bit 6) between the two reads. While the device is busy this bit flips on every read. When the two reads agree, the device has stopped and the operation succeeded. A second status bit (bit 5) reports an internal device failure. It only counts when a follow-up pair of reads still shows toggling. From these comparisons the block returns success, error or timeout.

A host pulses `start_i` with a cycle limit. The block then requests reads through a simple request/acknowledge port, and the bus logic behind that port owns the status address and the bus timing. Elapsed time is counted in clock cycles from the accepted start, and that count is checked against the limit before every iteration. A limit of zero times out at once. A limit of all ones turns the timeout off. The verdict is held with a done flag until the next start.

Top module: `nor_status_poller`

## Requirements
- R1: After reset `done_o` is 0, `result_o` is 0 (none) and `rd_req_o` is 0.
- R2: A read is issued by holding `rd_req_o` high. The read completes only in a cycle where `rd_ack_i` is also high, and `rd_data_i` is taken in that cycle. While `rd_ack_i` stays low, the request stays up and nothing is consumed.
- R3: If bit 6 has the same value in both reads of a pair, the result is success (code 1) after that pair. Every other bit of the status word is ignored in this comparison.
- R4: If bit 6 differs within the first pair of an iteration, a second pair is read whatever bit 5 showed in the first pair.
- R5: If bit 6 differs within the second pair and bit 5 was set in that pair's first read, the result is error (code 2). If bit 5 was clear in that read, a new iteration begins. Bit 5 in the second read is not considered.
- R6: Before each iteration the block compares the elapsed cycle count against the limit. The count is cleared on an accepted start, advances on every cycle until the result is reached, and saturates at its maximum. If the count exceeds the limit, the result is timeout (code 3) and no further read is issued.
- R7: A limit of 0 gives timeout with no read at all. `done_o` rises two cycles after the start is sampled.
- R8: A limit of all ones never times out, including after the elapsed count has saturated.
- R9: `done_o` and `result_o` hold until the next accepted start, which clears them. A start pulse while polling is in progress is ignored. The limit is sampled at the accepted start, and later changes on `tmo_limit_i` have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (accepted when not polling) |
| tmo_limit_i | input | CNT_W | Cycle limit; 0 = immediate, all ones = none |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read completes; data valid |
| rd_data_i | input | DATA_W | Status word returned by the read |
| done_o | output | 1 | Verdict available |
| result_o | output | 2 | 0 none, 1 success, 2 error, 3 timeout |

## Verification
The bench builds the poller with a 16-bit status word and an 8-bit cycle counter. At that counter width the all-ones "no timeout" limit of 255 can be exceeded in a few hundred cycles, so the bench runs a case past counter saturation and then ends it with a success. A limit of 254 shows that a finite limit still expires at the saturating edge. The small limits 0, 4 and 5 land the timeout before the first, second and third iteration, so the number of reads consumed pins down when the limit check happens.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

    // Verdict code presented on result_o
    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_OK   = 2'd1,
        RES_ERR  = 2'd2,
        RES_TMO  = 2'd3
    } poll_res_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOP  = 3'd1,
        ST_A_RD1 = 3'd2,
        ST_A_RD2 = 3'd3,
        ST_B_RD1 = 3'd4,
        ST_B_RD2 = 3'd5
    } poll_state_e;

    // Outcome of comparing one pair of status reads
    typedef enum logic [1:0] {
        V_STABLE = 2'd0,
        V_PAIR_B = 2'd1,
        V_FAULT  = 2'd2,
        V_RETRY  = 2'd3
    } pair_verdict_e;

    // Status bits kept from the first read of a pair
    typedef struct packed {
        logic tog;
        logic fail;
    } stat_bits_t;

    function automatic logic is_read_state(poll_state_e s);
        return (s == ST_A_RD1) || (s == ST_A_RD2) ||
               (s == ST_B_RD1) || (s == ST_B_RD2);
    endfunction

endpackage

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (run_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (lim_q == CNT_MAX)
            expired_o = 1'b0;
        else
            expired_o = (lim_q == '0) || (cnt_q > lim_q);
    end

    // R6: elapsed count never moves backwards between clears
    p_cnt_monotone_r6: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> cnt_q >= $past(cnt_q));

    // R9: the captured limit only changes on an accepted start
    p_lim_held_r9: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> $stable(lim_q));

endmodule

// File: rtl/nor_poll_capture.sv
module nor_poll_capture
    import nor_poll_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    output stat_bits_t        bits_o
);
    stat_bits_t bits_q;

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else if (load_i)
            bits_q <= '{tog: word_i[TOG_BIT], fail: word_i[FAIL_BIT]};
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
    import nor_poll_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int TOG_BIT = 6
) (
    input  stat_bits_t        first_i,
    input  logic [DATA_W-1:0] second_i,
    input  logic              pair_b_i,
    output pair_verdict_e     verdict_o
);
    always_comb begin
        if (first_i.tog == second_i[TOG_BIT])
            verdict_o = V_STABLE;
        else if (!pair_b_i)
            verdict_o = V_PAIR_B;
        else if (first_i.fail)
            verdict_o = V_FAULT;
        else
            verdict_o = V_RETRY;
    end

endmodule

// File: rtl/nor_status_poller.sv
module nor_status_poller
    import nor_poll_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int TOG_BIT  = 6,
    parameter int FAIL_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  tmo_limit_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic [1:0]        result_o
);
    poll_state_e   state_q;
    poll_res_e     res_q;
    logic          done_q;
    logic          accept;
    logic          expired;
    logic          rd_done;
    logic          cap_load;
    stat_bits_t    first_bits;
    pair_verdict_e verdict;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign rd_req_o = is_read_state(state_q);
    assign rd_done  = rd_req_o && rd_ack_i;
    assign cap_load = rd_done && ((state_q == ST_A_RD1) || (state_q == ST_B_RD1));

    nor_poll_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (accept),
        .run_i     (state_q != ST_IDLE),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    nor_poll_capture #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .FAIL_BIT(FAIL_BIT)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .load_i (cap_load),
        .word_i (rd_data_i),
        .bits_o (first_bits)
    );

    nor_poll_judge #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT)) u_judge (
        .first_i   (first_bits),
        .second_i  (rd_data_i),
        .pair_b_i  (state_q == ST_B_RD2),
        .verdict_o (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            res_q   <= RES_NONE;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LOOP;
                        res_q   <= RES_NONE;
                        done_q  <= 1'b0;
                    end
                end
                ST_LOOP: begin
                    if (expired) begin
                        state_q <= ST_IDLE;
                        res_q   <= RES_TMO;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_A_RD1;
                    end
                end
                ST_A_RD1: if (rd_ack_i) state_q <= ST_A_RD2;
                ST_B_RD1: if (rd_ack_i) state_q <= ST_B_RD2;
                ST_A_RD2, ST_B_RD2: begin
                    if (rd_ack_i) begin
                        unique case (verdict)
                            V_STABLE: begin
                                state_q <= ST_IDLE;
                                res_q   <= RES_OK;
                                done_q  <= 1'b1;
                            end
                            V_FAULT: begin
                                state_q <= ST_IDLE;
                                res_q   <= RES_ERR;
                                done_q  <= 1'b1;
                            end
                            V_PAIR_B: state_q <= ST_B_RD1;
                            V_RETRY:  state_q <= ST_LOOP;
                            default:  state_q <= ST_LOOP;
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = done_q;
    assign result_o = res_q;

    // R2: an unacknowledged read keeps its request up
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && !rd_ack_i |=> rd_req_o);

    // R6: once a verdict stands, no read is requested
    p_no_read_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !rd_req_o);

    // R7: zero limit times out two cycles after the start
    p_zero_limit_r7: assert property (@(posedge clk) disable iff (rst)
        accept && (tmo_limit_i == '0) |=> ##1 (done_o && result_o == RES_TMO));

    // R9: verdict holds while no new start arrives
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> done_o && $stable(result_o));

    // R9: a shown verdict always carries a real code
    p_code_valid_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> result_o != RES_NONE);

    // R9: an accepted start withdraws the previous verdict
    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done_o && result_o == RES_NONE);

endmodule

// File: tb/tb_nor_status_poller.sv
`timescale 1ns/1ps
module tb_nor_status_poller;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int NV = 11;

    // Sequences: word i sits at bits [16*i +: 16]
    localparam logic [127:0] ALT  = {8{32'h0040_0000}};
    localparam logic [127:0] ALL6 = {8{16'h0040}};

    localparam logic [7:0] V_LIM [NV] = '{8'd200, 8'd200, 8'd200, 8'd200, 8'd200, 8'd200,
                                          8'd4, 8'd5, 8'd0, 8'd255, 8'd254};
    localparam logic [127:0] V_SEQ [NV] = '{
        ALL6,                                                     // R3 first pair stable
        {{6{16'h0040}}, 16'h00C2, 16'h0041},                      // R3 other bits differ
        {{7{16'h0040}}, 16'h0000},                                // R4 second pair stable
        {64'h0, 16'h0060, 16'h0020, 16'h0040, 16'h0000},          // R5 fault
        {{5{16'h0040}}, 16'h0000, 16'h0040, 16'h0020},            // R4 R5 retry then ok
        {16'h0060, 16'h0020, 16'h0040, 16'h0000,
         16'h0060, 16'h0000, 16'h0040, 16'h0000},                 // R5 bit5 in 2nd read ignored
        ALT, ALT, ALT, ALT, ALT                                   // R6 R6 R7 R8 R6
    };
    localparam int V_STOP [NV] = '{1000, 1000, 1000, 1000, 1000, 1000,
                                   1000, 1000, 1000, 300, 1000};
    localparam logic [1:0] V_RES [NV] = '{2'd1, 2'd1, 2'd1, 2'd2, 2'd1, 2'd2,
                                          2'd3, 2'd3, 2'd3, 2'd1, 2'd3};
    localparam int V_READS [NV] = '{2, 2, 4, 4, 6, 8, 4, 8, 0, 302, 204};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] tmo_limit_i = '0;
    logic          rd_req_o;
    logic          rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          done_o;
    logic [1:0]    result_o;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    int stop_after = 1000;
    logic ack_en = 1'b1;
    logic [127:0] cur_seq = '0;

    always #2 clk = ~clk;

    nor_status_poller #(.DATA_W(DW), .CNT_W(CW), .TOG_BIT(6), .FAIL_BIT(5)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .tmo_limit_i(tmo_limit_i),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [DW-1:0] model_word(int i);
        if (i >= stop_after) return 16'h0040;
        if (i < 8) return cur_seq[16*i +: 16];
        return i[0] ? 16'h0040 : 16'h0000;
    endfunction

    // Flash status model: presents a word for each acknowledged read
    initial begin
        forever begin
            @(negedge clk);
            rd_ack_i = ack_en;
            if (rd_req_o && ack_en) begin
                rd_data_i = model_word(idx);
                idx++;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [CW-1:0] lim);
        @(negedge clk);
        tmo_limit_i = lim;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) check(1'b0, {tag, " watchdog"}, 0, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1 done", done_o, 0);
        check(result_o == 2'd0, "R1 result", result_o, 0);
        check(rd_req_o == 1'b0, "R1 req", rd_req_o, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            cur_seq = V_SEQ[v];
            stop_after = V_STOP[v];
            idx = 0;
            pulse_start(V_LIM[v]);
            wait_done($sformatf("vec%0d", v));
            check(result_o == V_RES[v], $sformatf("R3-R9 vec%0d result", v), result_o, V_RES[v]);
            check(idx == V_READS[v], $sformatf("R6 vec%0d reads", v), idx, V_READS[v]);
        end

        // R7 timing: done two cycles after the start is sampled
        cur_seq = ALT; stop_after = 1000; idx = 0;
        @(negedge clk);
        tmo_limit_i = 8'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R7 not yet done", done_o, 0);
        @(negedge clk);
        check(done_o == 1'b1 && result_o == 2'd3, "R7 done at 2nd edge", result_o, 3);
        check(idx == 0, "R7 no reads", idx, 0);

        // R9 verdict held, no reads while idle
        repeat (10) @(negedge clk);
        check(done_o == 1'b1 && result_o == 2'd3, "R9 hold", result_o, 3);
        check(idx == 0, "R9 idle no reads", idx, 0);

        // R9 restart while busy is ignored; limit change after start ignored
        cur_seq = ALT; stop_after = 1000; idx = 0;
        pulse_start(8'd4);
        check(done_o == 1'b0, "R9 start clears done", done_o, 0);
        tmo_limit_i = 8'd200;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R9 restart");
        check(result_o == 2'd3, "R9 busy start ignored result", result_o, 3);
        check(idx == 4, "R9 limit sampled at start reads", idx, 4);

        // R2 stalled bus: request holds, nothing consumed
        cur_seq = ALL6; stop_after = 1000; idx = 0;
        ack_en = 1'b0;
        pulse_start(8'd255);
        repeat (20) @(negedge clk);
        check(rd_req_o == 1'b1, "R2 request held", rd_req_o, 1);
        check(done_o == 1'b0, "R2 no verdict while stalled", done_o, 0);
        check(idx == 0, "R2 no read consumed", idx, 0);
        ack_en = 1'b1;
        wait_done("R2 stall");
        check(result_o == 2'd1, "R2 result after stall", result_o, 1);
        check(idx == 2, "R2 reads after stall", idx, 2);

        // R1 reset mid-run clears everything
        cur_seq = ALT; stop_after = 1000; idx = 0;
        pulse_start(8'd200);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && rd_req_o == 1'b0, "R1 reset mid-run", rd_req_o, 0);
        check(result_o == 2'd0, "R1 reset result", result_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule